// File: doc/BRIEF.md
# Strap Latch and Clock-Request Pin Router

This block is the configuration core of a clock generator with many outputs. Right after reset it captures three strap pads once. From then on those pads serve as PCI clock pins, and the captured values decide three things: whether overclocking is allowed, whether a pair of shared pins carries a differential SRC pair or two stop inputs, and whether a second differential pair runs as a debug-port clock or as a general SRC pair.

A small byte-wide register file stands in for the serial management bus. Two of its bytes control the pins. One byte holds per-pin tri-state controls for the PCI clocks. The other byte can turn the first two PCI pins into active-low clock-request inputs. Each request input is steered to one of two SRC pairs. A request is honoured only when the matching PCI pin has already been tri-stated. A request made without that is ignored and recorded in a sticky error flag.

The block drives a run enable for every SRC pair, every PCI clock, the CPU clocks and the debug clock. A run enable changes only on a clock edge that is flagged as falling in the low phase of the output clock, so gating never cuts a clock pulse short.

Top module: `clkcfg_router`

## Requirements
- R1: On the first rising clock edge after reset is released, the block captures the trusted, shared-pair and debug strap pads, and `straps_done_o` goes to 1.
- R2: Captured strap values never change until the next reset, whatever the pads do later.
- R3: `ovclk_allow_o` is 1 exactly when straps are captured and the trusted strap was 0.
- R4: With the shared-pair strap at 1, `src5_mode_o` is 1, SRC pair 5 may run and both stop inputs are ignored. With it at 0, pair 5 stays off. A low `pci_stop_n_i` then stops PCI clocks 0 to 4 and every SRC pair, and a low `cpu_stop_n_i` stops the CPU and debug clocks.
- R5: With the debug strap at 1, `itp_mode_o` is 1, the debug clock may run and SRC pair 8 stays off. With it at 0, the debug clock stays off and pair 8 may run.
- R6: PCI clock 5 is free-running: no stop input ever gates it once straps are captured.
- R7: The register file has 8 bytes, is addressed by `addr_i` and resets to 0. A strobe on `wr_en_i` writes `wdata_i` in one cycle. `rdata_o` always shows the addressed byte.
- R8: Setting bit n (n = 0..5) of byte 2 tri-states PCI clock n, so `pci_oe_o[n]` is 0. PCI pins 2, 4 and 5 share strap pads and stay tri-stated until the straps are captured.
- R9: In byte 5, bit 7 enables request A on PCI pin 0, and bit 6 routes it to SRC pair 0 (value 0) or pair 2 (value 1). Bit 5 enables request B on PCI pin 1, and bit 4 routes it to pair 1 (value 0) or pair 4 (value 1). An honoured request input held high stops its routed pair.
- R10: A request enable whose matching byte-2 bit is 0 is ignored: the pin remains a driven PCI clock and the request input has no effect. The attempt sets `cfg_err_o`, which stays 1 until reset.
- R11: Run enables are updated only at rising edges where `phase_low_i` is 1. At any other edge they hold.
- R12: Before straps are captured, every run enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_tm_i | input | 1 | Trusted-mode strap pad (shared with PCI2) |
| strap_s5_i | input | 1 | Shared-pair strap pad (shared with PCI4) |
| strap_itp_i | input | 1 | Debug-clock strap pad (shared with PCI5) |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register byte address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Addressed register byte |
| req_a_n_i | input | 1 | Active-low request input on PCI pin 0 |
| req_b_n_i | input | 1 | Active-low request input on PCI pin 1 |
| pci_stop_n_i | input | 1 | Active-low PCI/SRC stop input |
| cpu_stop_n_i | input | 1 | Active-low CPU stop input |
| phase_low_i | input | 1 | Marks an edge that falls in the output clock's low phase |
| straps_done_o | output | 1 | Straps have been captured |
| ovclk_allow_o | output | 1 | Overclocking permitted |
| src5_mode_o | output | 1 | Shared pins carry SRC pair 5 |
| itp_mode_o | output | 1 | Debug pair carries the debug clock |
| cfg_err_o | output | 1 | Sticky request-misconfiguration flag |
| pci_oe_o | output | 6 | PCI pin output enables |
| pci_run_o | output | 6 | PCI clock run enables |
| src_run_o | output | 9 | SRC pair run enables |
| cpu_run_o | output | 1 | CPU clock run enable |
| itp_run_o | output | 1 | Debug clock run enable |

## Verification
The strap flags, register contents, read data, output enables and error flag all settle one rising edge after their cause: the capture edge or the write edge. Run enables settle at the first rising edge where `phase_low_i` is 1, and they use the register and input values present just before that edge. The bench drives every input on the falling edge and lets one rising edge pass. It moves its model across that edge in the same order as the registers. It then compares every output at the next falling edge, so each result is sampled in the half-cycle after it is due.

// File: rtl/clkcfg_pkg.sv
`timescale 1ns/1ps
package clkcfg_pkg;
    localparam int NREG = 8;
    localparam int AW   = $clog2(NREG);
    localparam int DW   = 8;
    localparam int NPCI = 6;
    localparam int NSRC = 9;

    // register byte addresses
    localparam int REG_PCI_OFF = 2;
    localparam int REG_REQ     = 5;

    // request byte bit positions
    localparam int B_REQA_EN  = 7;
    localparam int B_REQA_SEL = 6;
    localparam int B_REQB_EN  = 5;
    localparam int B_REQB_SEL = 4;

    // SRC pair indices selected by requests and straps
    localparam int SRC_A0     = 0;
    localparam int SRC_A1     = 2;
    localparam int SRC_B0     = 1;
    localparam int SRC_B1     = 4;
    localparam int SRC_SHARED = 5;
    localparam int SRC_ALT    = 8;

    // PCI pins that share strap pads
    localparam int PCI_TM   = 2;
    localparam int PCI_S5   = 4;
    localparam int PCI_FREE = 5;

    typedef struct packed {
        logic tm;
        logic s5;
        logic itp;
    } strap_t;

    typedef struct packed {
        logic a_en;
        logic a_sel;
        logic b_en;
        logic b_sel;
    } req_cfg_t;
endpackage

// File: rtl/clkcfg_strap.sv
`timescale 1ns/1ps
module clkcfg_strap
    import clkcfg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  strap_t pad_i,
    output logic   done_o,
    output strap_t straps_o
);
    typedef struct packed {
        logic   done;
        strap_t s;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!st_q.done) begin
            st_d.done = 1'b1;
            st_d.s    = pad_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o   = st_q.done;
    assign straps_o = st_q.s;

    AST_DONE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st_q.done) |-> st_q.done); // R1
    AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && $past(st_q.done)) |-> $stable(st_q.s)); // R2
endmodule

// File: rtl/clkcfg_regs.sv
`timescale 1ns/1ps
module clkcfg_regs
    import clkcfg_pkg::*;
#(
    parameter int N_BYTES = NREG,
    parameter int W_DATA  = DW,
    localparam int W_ADDR = $clog2(N_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [W_ADDR-1:0] addr_i,
    input  logic [W_DATA-1:0] wdata_i,
    output logic [W_DATA-1:0] rdata_o,
    output logic [NPCI-1:0]   pci_off_o,
    output req_cfg_t          req_o,
    output logic              err_o
);
    typedef struct packed {
        logic [N_BYTES-1:0][W_DATA-1:0] mem;
        logic                           err;
    } st_t;

    st_t  st_q, st_d;
    logic conflict_d;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) st_d.mem[addr_i] = wdata_i;
        conflict_d = (st_d.mem[REG_REQ][B_REQA_EN] & ~st_d.mem[REG_PCI_OFF][0])
                   | (st_d.mem[REG_REQ][B_REQB_EN] & ~st_d.mem[REG_PCI_OFF][1]);
        st_d.err   = st_q.err | conflict_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o     = st_q.mem[addr_i];
    assign pci_off_o   = st_q.mem[REG_PCI_OFF][NPCI-1:0];
    assign req_o.a_en  = st_q.mem[REG_REQ][B_REQA_EN];
    assign req_o.a_sel = st_q.mem[REG_REQ][B_REQA_SEL];
    assign req_o.b_en  = st_q.mem[REG_REQ][B_REQB_EN];
    assign req_o.b_sel = st_q.mem[REG_REQ][B_REQB_SEL];
    assign err_o       = st_q.err;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st_q.err) |-> st_q.err); // R10
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en_i) |-> (st_q.mem[$past(addr_i)] == $past(wdata_i))); // R7
endmodule

// File: rtl/clkcfg_gate.sv
`timescale 1ns/1ps
module clkcfg_gate #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         phase_low_i,
    input  logic [W-1:0] want_i,
    output logic [W-1:0] run_o
);
    typedef struct packed {
        logic [W-1:0] run;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < W; i++) begin
            if (phase_low_i) st_d.run[i] = want_i[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_o = st_q.run;

    AST_HOLD_IN_HIGH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(phase_low_i) |-> $stable(st_q.run)); // R11
endmodule

// File: rtl/clkcfg_router.sv
`timescale 1ns/1ps
module clkcfg_router
    import clkcfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strap_tm_i,
    input  logic            strap_s5_i,
    input  logic            strap_itp_i,
    input  logic            wr_en_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [DW-1:0]   wdata_i,
    output logic [DW-1:0]   rdata_o,
    input  logic            req_a_n_i,
    input  logic            req_b_n_i,
    input  logic            pci_stop_n_i,
    input  logic            cpu_stop_n_i,
    input  logic            phase_low_i,
    output logic            straps_done_o,
    output logic            ovclk_allow_o,
    output logic            src5_mode_o,
    output logic            itp_mode_o,
    output logic            cfg_err_o,
    output logic [NPCI-1:0] pci_oe_o,
    output logic [NPCI-1:0] pci_run_o,
    output logic [NSRC-1:0] src_run_o,
    output logic            cpu_run_o,
    output logic            itp_run_o
);
    localparam int GW = NSRC + NPCI + 2;

    strap_t          pads, straps;
    logic            done;
    logic [NPCI-1:0] pci_off;
    req_cfg_t        req_cfg;
    logic [GW-1:0]   want, run;

    assign pads = '{tm: strap_tm_i, s5: strap_s5_i, itp: strap_itp_i};

    clkcfg_strap u_strap (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_i    (pads),
        .done_o   (done),
        .straps_o (straps)
    );

    clkcfg_regs #(.N_BYTES(NREG), .W_DATA(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .rdata_o   (rdata_o),
        .pci_off_o (pci_off),
        .req_o     (req_cfg),
        .err_o     (cfg_err_o)
    );

    logic            pci_stop, cpu_stop;
    logic            a_live, b_live, a_stop, b_stop;
    int              a_pair, b_pair;
    logic [NSRC-1:0] src_want;
    logic [NPCI-1:0] pci_want;

    always_comb begin
        pci_stop = done & ~straps.s5 & ~pci_stop_n_i;
        cpu_stop = done & ~straps.s5 & ~cpu_stop_n_i;
        a_live   = req_cfg.a_en & pci_off[0];
        b_live   = req_cfg.b_en & pci_off[1];
        a_stop   = a_live & req_a_n_i;
        b_stop   = b_live & req_b_n_i;
        a_pair   = req_cfg.a_sel ? SRC_A1 : SRC_A0;
        b_pair   = req_cfg.b_sel ? SRC_B1 : SRC_B0;
        for (int i = 0; i < NSRC; i++) begin
            src_want[i] = done & ~pci_stop;
            if (i == SRC_SHARED) src_want[i] = src_want[i] & straps.s5;
            if (i == SRC_ALT)    src_want[i] = src_want[i] & ~straps.itp;
            if (a_stop && (i == a_pair)) src_want[i] = 1'b0;
            if (b_stop && (i == b_pair)) src_want[i] = 1'b0;
        end
        for (int i = 0; i < NPCI; i++) begin
            pci_want[i] = (i == PCI_FREE) ? done : (done & ~pci_stop);
        end
        want = {done & straps.itp & ~cpu_stop, done & ~cpu_stop, pci_want, src_want};
    end

    clkcfg_gate #(.W(GW)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_low_i (phase_low_i),
        .want_i      (want),
        .run_o       (run)
    );

    assign src_run_o = run[NSRC-1:0];
    assign pci_run_o = run[NSRC +: NPCI];
    assign cpu_run_o = run[NSRC+NPCI];
    assign itp_run_o = run[NSRC+NPCI+1];

    for (genvar g = 0; g < NPCI; g++) begin : g_pci_oe
        if (g == PCI_TM || g == PCI_S5 || g == PCI_FREE) begin : g_shared
            assign pci_oe_o[g] = ~pci_off[g] & done;
        end else begin : g_plain
            assign pci_oe_o[g] = ~pci_off[g];
        end
    end

    assign straps_done_o = done;
    assign ovclk_allow_o = done & ~straps.tm;
    assign src5_mode_o   = done & straps.s5;
    assign itp_mode_o    = done & straps.itp;

    AST_PCI5_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pci_run_o[PCI_FREE]) |-> pci_run_o[PCI_FREE]); // R6
    AST_SRC5_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !straps.s5) |-> !src_run_o[SRC_SHARED]); // R4
    AST_PRE_STRAP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (run == '0)); // R12
    AST_REQ_A_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_cfg.a_en && pci_off[0] && req_a_n_i && phase_low_i)
        |-> !($past(req_cfg.a_sel) ? src_run_o[SRC_A1] : src_run_o[SRC_A0])); // R9
endmodule

// File: tb/clkcfg_router_test.sv
`timescale 1ns/1ps
module clkcfg_router_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_tm_i = 0, strap_s5_i = 0, strap_itp_i = 0;
    logic       wr_en_i = 0;
    logic [2:0] addr_i = 0;
    logic [7:0] wdata_i = 0;
    logic [7:0] rdata_o;
    logic       req_a_n_i = 0, req_b_n_i = 0, pci_stop_n_i = 1, cpu_stop_n_i = 1, phase_low_i = 0;
    logic       straps_done_o, ovclk_allow_o, src5_mode_o, itp_mode_o, cfg_err_o;
    logic [5:0] pci_oe_o, pci_run_o;
    logic [8:0] src_run_o;
    logic       cpu_run_o, itp_run_o;

    always #5 clk = ~clk;

    clkcfg_router uut (.*);

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    // model state
    logic [7:0] m_mem [8];
    logic       m_err, m_done, m_tm, m_s5, m_itp;
    logic [8:0] m_src;
    logic [5:0] m_pci;
    logic       m_cpu, m_itp_run;

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [5:0] exp_oe();
        logic [5:0] o;
        for (int i = 0; i < 6; i++) begin
            o[i] = ~m_mem[2][i];
            if (i == 2 || i == 4 || i == 5) o[i] = o[i] & m_done;
        end
        return o;
    endfunction

    function automatic logic [8:0] exp_src(input logic ra, input logic rb, input logic ps);
        logic [8:0] s;
        logic stop_all = m_done && !m_s5 && !ps;
        for (int i = 0; i < 9; i++) s[i] = m_done && !stop_all;
        if (!m_s5) s[5] = 0;
        if (m_itp) s[8] = 0;
        if (m_mem[5][7] && m_mem[2][0] && ra) s[m_mem[5][6] ? 2 : 0] = 0;
        if (m_mem[5][5] && m_mem[2][1] && rb) s[m_mem[5][4] ? 4 : 1] = 0;
        return s;
    endfunction

    task automatic check_all(input string ctx);
        chk({ctx, " R1 done"}, 16'(straps_done_o), 16'(m_done));
        chk({ctx, " R3 ovclk"}, 16'(ovclk_allow_o), 16'(m_done & ~m_tm));
        chk({ctx, " R4 src5 mode"}, 16'(src5_mode_o), 16'(m_done & m_s5));
        chk({ctx, " R5 itp mode"}, 16'(itp_mode_o), 16'(m_done & m_itp));
        chk({ctx, " R7 rdata"}, 16'(rdata_o), 16'(m_mem[addr_i]));
        chk({ctx, " R8 pci_oe"}, 16'(pci_oe_o), 16'(exp_oe()));
        chk({ctx, " R10 err"}, 16'(cfg_err_o), 16'(m_err));
        chk({ctx, " R9 src_run"}, 16'(src_run_o), 16'(m_src));
        chk({ctx, " R6 pci_run"}, 16'(pci_run_o), 16'(m_pci));
        chk({ctx, " R4 cpu_run"}, 16'(cpu_run_o), 16'(m_cpu));
        chk({ctx, " R5 itp_run"}, 16'(itp_run_o), 16'(m_itp_run));
    endtask

    task automatic step(input logic wr, input logic [2:0] ad, input logic [7:0] dat,
                        input logic ra, input logic rb, input logic ps, input logic cs,
                        input logic ph, input string ctx);
        wr_en_i = wr; addr_i = ad; wdata_i = dat;
        req_a_n_i = ra; req_b_n_i = rb; pci_stop_n_i = ps; cpu_stop_n_i = cs; phase_low_i = ph;
        strap_tm_i = 1'($urandom); strap_s5_i = 1'($urandom); strap_itp_i = 1'($urandom);
        @(posedge clk);
        if (ph) begin
            logic cstop = m_done && !m_s5 && !cs;
            logic pstop = m_done && !m_s5 && !ps;
            m_src = exp_src(ra, rb, ps);
            for (int i = 0; i < 5; i++) m_pci[i] = m_done && !pstop;
            m_pci[5]  = m_done;
            m_cpu     = m_done && !cstop;
            m_itp_run = m_done && m_itp && !cstop;
        end
        if (wr) m_mem[ad] = dat;
        if ((m_mem[5][7] && !m_mem[2][0]) || (m_mem[5][5] && !m_mem[2][1])) m_err = 1;
        m_done = 1;
        @(negedge clk);
        check_all(ctx);
    endtask

    task automatic do_reset(input logic [2:0] st);
        rst_n = 0;
        strap_tm_i = st[2]; strap_s5_i = st[1]; strap_itp_i = st[0];
        wr_en_i = 0; addr_i = 0; phase_low_i = 1;
        for (int i = 0; i < 8; i++) m_mem[i] = 0;
        m_err = 0; m_done = 0; m_src = 0; m_pci = 0; m_cpu = 0; m_itp_run = 0;
        m_tm = st[2]; m_s5 = st[1]; m_itp = st[0];
        repeat (2) @(negedge clk);
        check_all("reset R12");
        rst_n = 1;
        // capture edge: pads hold the chosen values
        @(posedge clk);
        m_done = 1;
        @(negedge clk);
        check_all("capture R1");
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        if (!finished) begin
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int r = 0; r < 8; r++) begin
            do_reset(3'(r));
            // R11: high-phase edges hold the run enables at their idle value
            for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0, 1, 1, 0, "hold R11");
            step(0, 0, 0, 0, 0, 1, 1, 1, "first run R11");
            // R10: request A without tri-state is ignored and flagged
            step(1, 5, 8'h80, 1, 1, 1, 1, 1, "req A no tristate R10");
            step(0, 5, 0, 1, 1, 1, 1, 1, "req A ignored R10");
            // R9: tri-state PCI0 and PCI1, then request A to pair 2, B to pair 4
            step(1, 2, 8'h03, 1, 1, 1, 1, 1, "tristate R8");
            step(1, 5, 8'hF0, 1, 0, 1, 1, 1, "route A2 B4 R9");
            step(0, 5, 0, 0, 1, 1, 1, 1, "route swap R9");
            step(1, 5, 8'hA0, 1, 1, 1, 1, 1, "route A0 B1 R9");
            // R4: stop inputs
            step(0, 2, 0, 0, 0, 0, 0, 1, "stop inputs low R4");
            step(0, 2, 0, 0, 0, 1, 1, 1, "stop inputs high R4");
            // constrained random mix
            for (int k = 0; k < 400; k++) begin
                logic [2:0] ad = ($urandom_range(0, 3) == 0) ? 3'($urandom) :
                                 (($urandom_range(0, 1) == 0) ? 3'd2 : 3'd5);
                step(($urandom_range(0, 3) == 0), ad, 8'($urandom),
                     1'($urandom), 1'($urandom), ($urandom_range(0, 3) != 0),
                     ($urandom_range(0, 3) != 0), 1'($urandom), "random R2 R7 R9 R11");
            end
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule